// File: doc/BRIEF.md
# TDM Sample Bus Slot Sequencer

This block paces a shared, time-division sample bus used by several processing engines. Each audio frame is announced by a one-cycle frame strobe. From then on the block walks through 64 slots. Each slot is four bus cycles long, so a frame lasts 256 bus cycles. In every cycle the block grants drive rights to the client that owns the current slot. It places that client's 24-bit word on the shared bus and publishes the slot and cycle indices beside it. Every client sees the bus in every cycle, so a word driven early in a frame can be picked up by any other client later in the same frame.

Slot ownership is fixed when the block is built. Source 0 is the router client and owns the reserved slots 0 to 7. Each general client `i` (source `i+1`) owns the single slot given by entry `i` of the `GEN_SLOT` parameter, which must lie in 8..63. A slot with no owner leaves the bus quiet. An owner that has no word ready in a cycle also leaves the bus quiet for that cycle: the word is zero and the valid flag is low.

The sequencer is a three-state machine. `SEQ_IDLE` is the state after reset, before any frame has started. `SEQ_RUN` walks through the frame positions. `SEQ_WAIT` means a frame has finished and the next strobe has not yet come.

The transitions are:
- IDLE→RUN when a strobe arrives.
- RUN→RUN, restarting at position 0, when a strobe arrives. If the strobe comes before the last cycle, the frame is cut short and the overrun flag is set.
- RUN→WAIT after the last cycle of slot 63 when no strobe arrives.
- WAIT→RUN when a strobe arrives.

Top module: `tdm_slot_sequencer`

## Requirements
- R1: After reset: `seq_active`, `bus_vld`, `frame_ovr` and every `src_grant` bit are 0; `bus_word`, `bus_slot` and `bus_cyc` are 0.
- R2: A strobe sampled on a clock edge places the sequencer at slot 0, cycle 0 with `seq_active` high from that edge. Each later edge advances the cycle index 0,1,2,3 and then moves to cycle 0 of the next slot, so a frame spans 256 edges.
- R3: After slot 63 cycle 3, an edge with no strobe drops `seq_active`. The bus then stays quiet (no grant, `bus_vld` 0, slot and cycle 0) until the next strobe.
- R4: While active in slots 0 to 7, only `src_grant[0]` (the router) is high.
- R5: While active in a general client's configured slot, that client's grant bit is high for all four cycles. In slots 8..63 that no client owns, no grant is high.
- R6: At most one grant bit is high in any cycle.
- R7: When the granted source has its valid bit high, `bus_word` equals that source's word and `bus_vld` is 1.
- R8: When the granted source's valid bit is low, or no source is granted, `bus_word` is 0 and `bus_vld` is 0. Words and valid bits of sources that are not granted have no effect on the bus.
- R9: A strobe while active at any position other than slot 63 cycle 3 restarts the frame at position 0 and sets `frame_ovr`, which then stays high until reset. A strobe exactly at slot 63 cycle 3 restarts without setting it.
- R10: A strobe in the idle or waiting state starts a frame without setting `frame_ovr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_go | input | 1 | Frame strobe, one cycle |
| src_word | input | N_SRC x DATA_W | Word offered by each source (index 0 is the router) |
| src_vld | input | N_SRC | Per-source word-ready flag |
| src_grant | output | N_SRC | Drive right for the current slot, one bit per source |
| bus_word | output | DATA_W | Shared bus data |
| bus_vld | output | 1 | Shared bus data is valid |
| bus_slot | output | 6 | Current slot index |
| bus_cyc | output | 2 | Current cycle within the slot |
| seq_active | output | 1 | A frame is in progress |
| frame_ovr | output | 1 | Sticky flag: a frame was cut short |

## Verification
The bus is driven through whole frames with four source patterns:
- Every source valid. This shows the ownership map across all 64 slots, including the router range edge at slot 8 and a client in slot 63.
- Random valid bits. These separate the owner's valid from those of non-owners.
- Only non-owners valid. This shows that foreign data never leaks onto the bus.
- All sources idle.

Strobe placement is varied to tell the three cases apart:
- a strobe after the frame has ended,
- a strobe exactly on the final cycle (back-to-back frames, no overrun),
- a strobe in mid-frame, where the frame is cut short and the sticky flag must stay set.

// File: rtl/tdm_seq_pkg.sv
package tdm_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
    import tdm_seq_pkg::*;
#(
    parameter int N_SLOTS      = 64,
    parameter int CYC_PER_SLOT = 4,
    parameter int SLOT_W       = 6,
    parameter int CYC_W        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_go,
    output logic              active,
    output logic [SLOT_W-1:0] slot,
    output logic [CYC_W-1:0]  cyc,
    output logic              overrun
);

    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(N_SLOTS - 1);
    localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(CYC_PER_SLOT - 1);

    seq_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [CYC_W-1:0]  cyc_q, cyc_d;
    logic              ovr_q, ovr_d;
    logic              at_last;

    assign at_last = (slot_q == SLOT_LAST) && (cyc_q == CYC_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            slot_q  <= '0;
            cyc_q   <= '0;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            cyc_q   <= cyc_d;
            ovr_q   <= ovr_d;
        end
    end

    // next state and position
    always_comb begin
        state_d = state_q;
        slot_d  = '0;
        cyc_d   = '0;
        ovr_d   = ovr_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (frame_go) state_d = SEQ_RUN;
            end
            SEQ_RUN: begin
                if (frame_go) begin
                    state_d = SEQ_RUN;
                    if (!at_last) ovr_d = 1'b1;
                end else if (at_last) begin
                    state_d = SEQ_WAIT;
                end else if (cyc_q == CYC_LAST) begin
                    slot_d = slot_q + 1'b1;
                end else begin
                    slot_d = slot_q;
                    cyc_d  = cyc_q + 1'b1;
                end
            end
            SEQ_WAIT: begin
                if (frame_go) state_d = SEQ_RUN;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        active  = (state_q == SEQ_RUN);
        slot    = slot_q;
        cyc     = cyc_q;
        overrun = ovr_q;
    end

    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_go |=> (active && slot == '0 && cyc == '0));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !frame_go && !at_last) |=> (active &&
            (($past(cyc) == CYC_LAST) ? (cyc == '0 && slot == $past(slot) + 1'b1)
                                      : (cyc == $past(cyc) + 1'b1 && slot == $past(slot)))));

    p_frame_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && at_last && !frame_go) |=> !active);

    p_ovr_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !at_last && frame_go) |=> overrun);

    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    p_ovr_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !overrun) |=> !overrun);

endmodule

// File: rtl/tdm_owner_decode.sv
module tdm_owner_decode #(
    parameter int N_GEN        = 3,
    parameter int N_SRC        = N_GEN + 1,
    parameter int SLOT_W       = 6,
    parameter int ROUTER_SLOTS = 8,
    parameter int GEN_SLOT [N_GEN] = '{8, 33, 63}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [SLOT_W-1:0] slot,
    output logic [N_SRC-1:0]  grant
);

    always_comb begin
        grant[0] = active && (32'(slot) < ROUTER_SLOTS);
    end

    for (genvar g = 0; g < N_GEN; g++) begin : g_gen_owner
        always_comb begin
            grant[g+1] = active && (32'(slot) == GEN_SLOT[g]);
        end
    end

    p_one_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_router_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && 32'(slot) < ROUTER_SLOTS) |-> (grant == N_SRC'(1)));

    p_idle_no_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (grant == '0));

endmodule

// File: rtl/tdm_bus_mux.sv
module tdm_bus_mux #(
    parameter int N_SRC  = 4,
    parameter int DATA_W = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_SRC-1:0]             grant,
    input  logic [N_SRC-1:0][DATA_W-1:0] src_word,
    input  logic [N_SRC-1:0]             src_vld,
    output logic [DATA_W-1:0]            bus_word,
    output logic                         bus_vld
);

    logic [N_SRC-1:0] drive;

    assign drive = grant & src_vld;

    always_comb begin
        bus_word = '0;
        for (int s = 0; s < N_SRC; s++) begin
            bus_word = bus_word | (src_word[s] & {DATA_W{drive[s]}});
        end
        bus_vld = |drive;
    end

    p_quiet_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_vld |-> (bus_word == '0));

    p_no_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |-> !bus_vld);

endmodule

// File: rtl/tdm_slot_sequencer.sv
module tdm_slot_sequencer #(
    parameter int N_GEN        = 3,
    parameter int GEN_SLOT [N_GEN] = '{8, 33, 63},
    parameter int DATA_W       = 24,
    parameter int N_SLOTS      = 64,
    parameter int CYC_PER_SLOT = 4,
    parameter int ROUTER_SLOTS = 8,
    localparam int N_SRC       = N_GEN + 1,
    localparam int SLOT_W      = $clog2(N_SLOTS),
    localparam int CYC_W       = $clog2(CYC_PER_SLOT)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_go,
    input  logic [N_SRC-1:0][DATA_W-1:0] src_word,
    input  logic [N_SRC-1:0]             src_vld,
    output logic [N_SRC-1:0]             src_grant,
    output logic [DATA_W-1:0]            bus_word,
    output logic                         bus_vld,
    output logic [SLOT_W-1:0]            bus_slot,
    output logic [CYC_W-1:0]             bus_cyc,
    output logic                         seq_active,
    output logic                         frame_ovr
);

    tdm_frame_timer #(
        .N_SLOTS     (N_SLOTS),
        .CYC_PER_SLOT(CYC_PER_SLOT),
        .SLOT_W      (SLOT_W),
        .CYC_W       (CYC_W)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_go(frame_go),
        .active  (seq_active),
        .slot    (bus_slot),
        .cyc     (bus_cyc),
        .overrun (frame_ovr)
    );

    tdm_owner_decode #(
        .N_GEN       (N_GEN),
        .N_SRC       (N_SRC),
        .SLOT_W      (SLOT_W),
        .ROUTER_SLOTS(ROUTER_SLOTS),
        .GEN_SLOT    (GEN_SLOT)
    ) owner_i (
        .clk   (clk),
        .rst_n (rst_n),
        .active(seq_active),
        .slot  (bus_slot),
        .grant (src_grant)
    );

    tdm_bus_mux #(
        .N_SRC (N_SRC),
        .DATA_W(DATA_W)
    ) mux_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant   (src_grant),
        .src_word(src_word),
        .src_vld (src_vld),
        .bus_word(bus_word),
        .bus_vld (bus_vld)
    );

endmodule

// File: tb/tdm_slot_sequencer_tb_top.sv
`timescale 1ns/1ps
module tdm_slot_sequencer_tb_top;

    localparam int NG = 3;
    localparam int NS = NG + 1;
    localparam int DW = 24;
    localparam int TB_SLOTS [NG] = '{8, 33, 63};

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               frame_go = 1'b0;
    logic [NS-1:0][DW-1:0] src_word = '0;
    logic [NS-1:0]      src_vld = '0;
    logic [NS-1:0]      src_grant;
    logic [DW-1:0]      bus_word;
    logic               bus_vld;
    logic [5:0]         bus_slot;
    logic [1:0]         bus_cyc;
    logic               seq_active;
    logic               frame_ovr;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // reference model state
    int  m_pos = 0;
    bit  m_act = 1'b0;
    bit  m_ovr = 1'b0;

    always #5 clk = ~clk;

    tdm_slot_sequencer #(.N_GEN(NG), .GEN_SLOT(TB_SLOTS), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_go(frame_go),
        .src_word(src_word), .src_vld(src_vld), .src_grant(src_grant),
        .bus_word(bus_word), .bus_vld(bus_vld), .bus_slot(bus_slot),
        .bus_cyc(bus_cyc), .seq_active(seq_active), .frame_ovr(frame_ovr)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_act = 1'b0; m_ovr = 1'b0;
        end else if (frame_go) begin
            if (m_act && m_pos != 255) m_ovr = 1'b1;
            m_act = 1'b1; m_pos = 0;
        end else if (m_act) begin
            if (m_pos == 255) begin m_act = 1'b0; m_pos = 0; end
            else m_pos = m_pos + 1;
        end
    end

    function automatic int owner_of(int slot);
        if (slot < 8) return 0;
        for (int i = 0; i < NG; i++) if (TB_SLOTS[i] == slot) return i + 1;
        return -1;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (pos=%0d)", req, act, exp, m_pos);
        end
    endtask

    task automatic compare_all(string tag_pos, string tag_own);
        int own;
        logic [NS-1:0] e_gr;
        logic [DW-1:0] e_w;
        bit e_v;
        own = m_act ? owner_of(m_pos / 4) : -1;
        e_gr = '0;
        if (own >= 0) e_gr[own] = 1'b1;
        e_v = (own >= 0) && src_vld[own];
        e_w = e_v ? src_word[own] : '0;
        chk(seq_active == m_act, tag_pos, seq_active, m_act);
        chk(bus_slot == 6'(m_act ? m_pos / 4 : 0), tag_pos, bus_slot, m_pos / 4);
        chk(bus_cyc == 2'(m_act ? m_pos % 4 : 0), tag_pos, bus_cyc, m_pos % 4);
        chk(src_grant == e_gr, tag_own, src_grant, e_gr);
        chk($countones(src_grant) <= 1, "R6", src_grant, e_gr);
        chk(bus_vld == e_v, e_v ? "R7" : "R8", bus_vld, e_v);
        chk(bus_word == e_w, e_v ? "R7" : "R8", bus_word, e_w);
        chk(frame_ovr == m_ovr, "R9/R10", frame_ovr, m_ovr);
    endtask

    // vmode: 0 all valid, 1 random, 2 only non-owners valid, 3 none
    task automatic step(bit go, int vmode);
        int own;
        @(negedge clk);
        frame_go = go;
        for (int s = 0; s < NS; s++) src_word[s] = DW'($urandom);
        own = m_act ? owner_of(m_pos / 4) : -1;
        case (vmode)
            0: src_vld = '1;
            1: src_vld = NS'($urandom);
            2: begin src_vld = '1; if (own >= 0) src_vld[own] = 1'b0; end
            default: src_vld = '0;
        endcase
        #1;
        compare_all(m_act ? "R2" : "R3", (m_pos / 4 < 8) ? "R4" : "R5");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!seq_active && !bus_vld && !frame_ovr && src_grant == '0, "R1", seq_active, 0);
        chk(bus_word == '0 && bus_slot == '0 && bus_cyc == '0, "R1", bus_word, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) step(1'b0, 0);
        // R10: strobe from idle
        step(1'b1, 0);
        for (int i = 0; i < 256; i++) step(1'b0, 0);
        // R3: quiet after the frame has ended
        for (int i = 0; i < 6; i++) step(1'b0, 0);
        // R10: strobe from waiting
        step(1'b1, 1);
        for (int i = 0; i < 255; i++) step(1'b0, 1);
        // R9: strobe exactly on the last cycle, no overrun
        step(1'b1, 2);
        for (int i = 0; i < 255; i++) step(1'b0, 2);
        chk(frame_ovr == 1'b0, "R9", frame_ovr, 0);
        step(1'b1, 3);
        for (int i = 0; i < 100; i++) step(1'b0, 1);
        // R9: mid-frame strobe truncates and sets sticky overrun
        step(1'b1, 1);
        step(1'b0, 0);
        chk(frame_ovr == 1'b1, "R9", frame_ovr, 1);
        for (int i = 0; i < 300; i++) step(1'b0, 1);
        chk(frame_ovr == 1'b1, "R9", frame_ovr, 1);
        step(1'b1, 0);
        for (int i = 0; i < 40; i++) step(1'b0, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule